// File: doc/BRIEF.md
# Gated Asymmetric Carrier Generator

The block builds a square-wave carrier from a count-clock enable. Its low and high phases have separate lengths, each set by its own compare value, so the duty cycle can be anything. One counter serves both phases. It counts count-clock ticks, and when it equals the compare value of the current phase it clears, toggles the carrier and moves to the other compare value. Each toggle also gives a one-cycle match pulse.

A modulation gate decides whether the carrier reaches the gated output. Software writes a buffer bit. An external interval pulse copies that bit into the active gate bit, after passing through a synchronizer clocked on the count-clock enable with rising-edge detection. The gated output changes only at carrier edges. A gate that opens mid-pulse waits for the next carrier rise. A gate that closes mid-pulse lets the current high phase finish at full width.

Top module: `gated_carrier_gen`

## Requirements
- R1: While `en_i` is low, `carrier_o`, `gated_o` and `match_o` stay 0, including directly after reset, whatever `tick_i` does.
- R2: After `en_i` rises, with a tick in every cycle, `carrier_o` stays low for `cmp_lo_i`+1 ticks. It first reads 1 in the (`cmp_lo_i`+1)-th cycle after the enabling edge.
- R3: The counter advances only on cycles with `tick_i` = 1. In steady state the high phase lasts (`cmp_hi_i`+1) ticks and the low phase lasts (`cmp_lo_i`+1) ticks. The carrier changes only on a compare match.
- R4: `match_o` is high for one clock cycle right after each carrier toggle, so there are exactly two pulses per carrier period. Each pulse coincides with a counter value of 0.
- R5: Each rising edge of `ext_pulse_i` gives exactly one gate transfer. Holding `ext_pulse_i` high and then changing `gate_buf_i` has no effect.
- R6: The active gate takes the value of `gate_buf_i` at the third tick edge that samples `ext_pulse_i` high.
- R7: When the active gate becomes 1, `gated_o` stays 0 for the rest of any current high phase. It follows the carrier from the next carrier rise, for that rise's full high phase.
- R8: When the active gate becomes 0 while the carrier is high, `gated_o` stays 1 until the carrier falls. It then stays 0.
- R9: When a gate transfer and a carrier rise fall on the same clock edge, the newly transferred gate value governs the pulse that is starting.
- R10: Clearing `en_i` forces the counter, carrier and gate to 0 on the next edge and selects the low-phase compare value again. After re-enabling, the first pulse is not passed without a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds and clears the block |
| tick_i | input | 1 | Count-clock enable |
| cmp_lo_i | input | CntW | Low-phase compare value |
| cmp_hi_i | input | CntW | High-phase compare value |
| gate_buf_i | input | 1 | Buffered modulation gate bit |
| ext_pulse_i | input | 1 | External interval pulse, asynchronous to ticks |
| carrier_o | output | 1 | Ungated carrier |
| gated_o | output | 1 | Carrier after the modulation gate |
| match_o | output | 1 | One-cycle pulse on every compare match |

## Verification
A synchronized gate transfer and a carrier rise can land on the same clock edge. That edge decides whether the starting pulse is passed. The bench enables the block and raises the external pulse in the same cycle, with a low-phase compare of 2, so the three-edge synchronizer delivers its transfer exactly on the first carrier rise. The gated output must then be high in the first high cycle. Raising the pulse one cycle later moves the transfer past the rise, and the gated output must stay low for that whole pulse.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/carrier_counter.sv
module carrier_counter
  import carrier_pkg::*;
#(
  parameter int unsigned CntW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [CntW-1:0] cmp_lo_i,
  input  logic [CntW-1:0] cmp_hi_i,
  output logic            carrier_o,
  output logic            rise_o,
  output logic            match_o
);
  localparam logic [CntW-1:0] One = {{(CntW-1){1'b0}}, 1'b1};

  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] cmp_sel;
  phase_e          phase_q;
  logic            match_q;
  logic            hit;

  always_comb begin
    cmp_sel = (phase_q == PH_LOW) ? cmp_lo_i : cmp_hi_i;
    hit     = (cnt_q == cmp_sel);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
      match_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
      match_q <= 1'b0;
    end else begin
      match_q <= tick_i & hit;
      if (tick_i) begin
        if (hit) begin
          cnt_q   <= '0;
          phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
        end else begin
          cnt_q <= cnt_q + One;
        end
      end
    end
  end

  // carrier equals the phase bit: low phase compares against cmp_lo_i
  assign carrier_o = (phase_q == PH_HIGH);
  assign rise_o    = en_i & tick_i & hit & (phase_q == PH_LOW);
  assign match_o   = match_q;

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && (phase_q == PH_LOW) && !match_q);

  p_clear_on_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> (cnt_q == '0));

  p_toggle_on_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> (phase_q != $past(phase_q)));

  p_change_needs_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q != $past(phase_q)) && $past(en_i)) |-> match_q);
endmodule

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int unsigned Stages = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic async_i,
  output logic pulse_o
);
  // Stages synchronizer flops plus one edge-detect flop, all advancing on ticks
  logic [Stages:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (tick_i) sh_q <= {sh_q[Stages-1:0], async_i};
  end

  assign pulse_o = tick_i & sh_q[Stages-1] & ~sh_q[Stages];

  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic xfer_i,
  input  logic buf_i,
  input  logic carrier_i,
  input  logic rise_i,
  output logic out_o
);
  logic gate_q;
  logic pass_q;
  logic gate_nxt;

  // a same-edge transfer wins over the old gate for the starting pulse
  assign gate_nxt = xfer_i ? buf_i : gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (!en_i) begin
      gate_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      gate_q <= gate_nxt;
      if (rise_i) pass_q <= gate_nxt;
    end
  end

  assign out_o = carrier_i & pass_q;

  p_disable_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_q && !out_o);

  p_no_truncate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(out_o) && $past(carrier_i) && carrier_i) |-> out_o);

  p_rise_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o && !$past(out_o)) |-> !$past(carrier_i));
endmodule

// File: rtl/gated_carrier_gen.sv
module gated_carrier_gen #(
  parameter int unsigned CntW       = 8,
  parameter int unsigned SyncStages = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic [CntW-1:0] cmp_lo_i,
  input  logic [CntW-1:0] cmp_hi_i,
  input  logic            gate_buf_i,
  input  logic            ext_pulse_i,
  output logic            carrier_o,
  output logic            gated_o,
  output logic            match_o
);
  logic rise;
  logic xfer;

  carrier_counter #(.CntW(CntW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_i),
    .cmp_lo_i (cmp_lo_i),
    .cmp_hi_i (cmp_hi_i),
    .carrier_o(carrier_o),
    .rise_o   (rise),
    .match_o  (match_o)
  );

  pulse_sync #(.Stages(SyncStages)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .async_i(ext_pulse_i),
    .pulse_o(xfer)
  );

  gate_ctrl u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .xfer_i   (xfer),
    .buf_i    (gate_buf_i),
    .carrier_i(carrier_o),
    .rise_i   (rise),
    .out_o    (gated_o)
  );
endmodule

// File: tb/sim_gated_carrier_gen.sv
module sim_gated_carrier_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tick;
  logic       gbuf = 1'b0;
  logic       ext = 1'b0;
  logic [7:0] lo = '0;
  logic [7:0] hi = '0;
  logic       carrier, gated, match;
  int         div = 1;
  int         nchk = 0;
  int         nfail = 0;

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic [3:0] dv;
  } vec_t;
  localparam int NVEC = 6;
  localparam vec_t VEC[NVEC] = '{
    '{8'd3, 8'd3, 4'd1},
    '{8'd0, 8'd5, 4'd1},
    '{8'd7, 8'd1, 4'd1},
    '{8'd2, 8'd4, 4'd3},
    '{8'd0, 8'd0, 4'd1},
    '{8'd1, 8'd0, 4'd2}
  };

  gated_carrier_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .cmp_lo_i(lo), .cmp_hi_i(hi), .gate_buf_i(gbuf), .ext_pulse_i(ext),
    .carrier_o(carrier), .gated_o(gated), .match_o(match)
  );

  always #5 clk = ~clk;

  initial begin
    int c;
    c = 0;
    tick = 1'b1;
    forever begin
      @(negedge clk);
      if (c >= div - 1) c = 0;
      else c = c + 1;
      tick = (c == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_level(input logic lvl);
    for (int g = 0; g < 3000 && carrier != lvl; g++) @(negedge clk);
  endtask

  task automatic wait_rise();
    wait_level(1'b0);
    wait_level(1'b1);
  endtask

  task automatic restart(input int l, input int h);
    en = 1'b0; ext = 1'b0;
    cyc(6);
    lo = 8'(l); hi = 8'(h);
    en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int k, hc, lc, mc, bad;
    cyc(3);
    chk("R1 reset carrier", int'(carrier), 0);
    chk("R1 reset gated", int'(gated), 0);
    chk("R1 reset match", int'(match), 0);
    rst_n = 1'b1;

    // R1: disabled with ticks running
    lo = 8'd1; hi = 8'd1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (carrier || gated || match) bad++;
    end
    chk("R1 idle activity", bad, 0);

    // vector table: R2 first phase, R3 phase lengths, R4 match count
    for (int i = 0; i < NVEC; i++) begin
      en = 1'b0;
      div = int'(VEC[i].dv);
      lo = VEC[i].lo; hi = VEC[i].hi;
      cyc(6);
      en = 1'b1;
      if (div == 1) begin
        k = 0;
        for (int j = 1; j < 600; j++) begin
          @(negedge clk);
          if (carrier) begin k = j; break; end
        end
        chk("R2 first rise cycle", k, int'(VEC[i].lo) + 1);
      end else begin
        wait_level(1'b1);
      end
      hc = 0; lc = 0; mc = 0;
      for (int g = 0; g < 3000 && carrier; g++) begin
        hc++; mc += int'(match); @(negedge clk);
      end
      for (int g = 0; g < 3000 && !carrier; g++) begin
        lc++; mc += int'(match); @(negedge clk);
      end
      chk("R3 high length", hc, (int'(VEC[i].hi) + 1) * div);
      chk("R3 low length", lc, (int'(VEC[i].lo) + 1) * div);
      chk("R4 matches per period", mc, 2);
      chk("R7 gate closed output", int'(gated), 0);
    end
    div = 1;

    // R7: gate opens mid-pulse
    restart(20, 20);
    gbuf = 1'b1;
    wait_rise();
    cyc(1); ext = 1'b1; cyc(2); ext = 1'b0; cyc(4);
    chk("R7 no mid-pulse start", int'(gated), 0);
    wait_rise();
    hc = 0;
    for (int g = 0; g < 3000 && carrier; g++) begin
      hc += int'(gated); @(negedge clk);
    end
    chk("R7 full pulse passed", hc, 21);

    // R8: gate closes mid-pulse
    wait_rise();
    cyc(1); gbuf = 1'b0; ext = 1'b1; cyc(2); ext = 1'b0; cyc(4);
    chk("R8 held after close", int'(gated), 1);
    bad = 0;
    for (int g = 0; g < 3000 && carrier; g++) begin
      if (!gated) bad++;
      @(negedge clk);
    end
    chk("R8 no truncation", bad, 0);
    chk("R8 low after fall", int'(gated), 0);
    wait_rise();
    chk("R8 stays closed", int'(gated), 0);

    // R5 and R6: one transfer per rising edge of the pulse
    gbuf = 1'b1; ext = 1'b1;
    cyc(6);
    gbuf = 1'b0;
    cyc(10);
    wait_rise();
    chk("R5 single transfer", int'(gated), 1);
    ext = 1'b0;

    // R10: disable clears state
    wait_rise();
    cyc(2);
    en = 1'b0;
    cyc(1);
    chk("R10 carrier cleared", int'(carrier), 0);
    chk("R10 gated cleared", int'(gated), 0);
    chk("R1 match cleared", int'(match), 0);
    gbuf = 1'b1;
    cyc(3);
    lo = 8'd4; hi = 8'd9;
    en = 1'b1;
    k = 0;
    for (int j = 1; j < 600; j++) begin
      @(negedge clk);
      if (carrier) begin k = j; break; end
    end
    chk("R10 low compare reselected", k, 5);
    chk("R10 gate cleared", int'(gated), 0);

    // R9 and R6: transfer on the same edge as the first rise
    en = 1'b0; ext = 1'b0; gbuf = 1'b1;
    lo = 8'd2; hi = 8'd10;
    cyc(6);
    en = 1'b1; ext = 1'b1;
    cyc(3);
    chk("R2 rise at cycle 3", int'(carrier), 1);
    chk("R9 same-edge transfer passes", int'(gated), 1);
    ext = 1'b0;

    // R9: transfer one edge after the rise
    en = 1'b0;
    cyc(6);
    en = 1'b1;
    cyc(1); ext = 1'b1;
    cyc(2);
    chk("R9 late transfer carrier", int'(carrier), 1);
    chk("R9 late transfer blocked", int'(gated), 0);
    cyc(1);
    chk("R7 late gate waits", int'(gated), 0);
    ext = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule